// File: doc/BRIEF.md
# Parallel NOR Flash Program Sequencer

This block sits on the host side of a 32-bit flash array made of four byte-wide NOR devices. The four byte lanes each have their own chip-select and write-enable. Output-enable and the address bus are shared by all lanes. A client sends one request at a time on a valid/ready port: a word read, a word program, an erase of any set of the eight sectors, or a whole-chip erase.

The sequencer produces the unlock and command bus writes. The same command byte goes onto every lane. Each strobe width comes from a clock-cycle counter, and the counter limits are derived from nanosecond parameters and the clock period. After the final command write, the sequencer reads the array again and again. It checks bit 7 of every lane on its own until all four lanes show true data, or until a poll limit is reached. The response returns the read word and an error flag.

Top module: `nor_seq`

## Requirements
- R1: After reset, `req_ready_o` is 1. All chip-selects, write-enables and `fl_oe_no` are 1. `fl_dq_oe_o` is 0 and `rsp_valid_o` is 0.
- R2: Operation code 0 (read) performs one read cycle at `req_addr_i`. In that cycle chip-selects and `fl_oe_no` are low for RD_CYC = ceil(T_ACC_NS/CLK_NS) clocks, with no write strobe. The response carries the sampled word with `rsp_err_o` = 0.
- R3: Operation code 1 (program) performs exactly four writes, in this order: (0x5555, 0xAAAAAAAA), (0x2AAA, 0x55555555), (0x5555, 0xA0A0A0A0), then (`req_addr_i`, `req_data_i`).
- R4: Every write holds write-enable low for LOW_CYC = ceil(max(T_WP_NS, T_AH_NS, T_DS_NS)/CLK_NS) clocks. Write-enable stays high for at least ceil(T_WPH_NS/CLK_NS) clocks between writes. Chip-select is low and output-enable is high while write-enable is low. All four lanes' strobes always move together.
- R5: Operation code 2 (sector erase) writes five prefix words in this order: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA. It then writes one 0x30 word at address sector<<14 for each set bit of `req_sect_i`, in ascending sector order.
- R6: Operation code 3 (chip erase) writes the same five prefix words as R5, then (0x5555, 0x10101010), and nothing more.
- R7: After the last write, output-enable stays high for at least ceil(T_OEH_NS/CLK_NS) clocks. Poll reads then follow. The poll address is `req_addr_i` for a program, the lowest selected sector base for a sector erase, and 0 for a chip erase. Lane l is complete when bit 8l+7 equals its expected value: the written bit for a program, 1 for an erase. A completed lane stays complete for the rest of the operation. The operation responds without error on the first poll after which all lanes are complete, and returns that poll's word.
- R8: If the lanes are not all complete after POLL_MAX poll reads, the response has `rsp_err_o` = 1 and no further read is issued.
- R9: A sector erase with an all-zero `req_sect_i` responds with `rsp_err_o` = 1 and issues no bus cycle.
- R10: `req_ready_o` is low from acceptance until the response. Each accepted request gives exactly one `rsp_valid_o` pulse, one cycle long, after which `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request taken |
| req_op_i | input | 2 | 0 read, 1 program, 2 sector erase, 3 chip erase |
| req_addr_i | input | 17 | Word address for read and program |
| req_data_i | input | 32 | Word to program |
| req_sect_i | input | 8 | Sector select mask for sector erase |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Timeout or empty sector mask |
| rsp_data_o | output | 32 | Read word or last poll word |
| fl_addr_o | output | 17 | Flash address bus |
| fl_dq_o | output | 32 | Flash write data |
| fl_dq_oe_o | output | 1 | Drive enable for the data bus |
| fl_dq_i | input | 32 | Flash read data |
| fl_cs_no | output | 4 | Per-lane chip-selects, active low |
| fl_we_no | output | 4 | Per-lane write-enables, active low |
| fl_oe_no | output | 1 | Shared output-enable, active low |

## Verification
The hardest case to reach from the ports is the one where lanes finish at different polls and a lane that has already finished reads back as busy again. Only the sticky per-lane state can then end the operation. The bench flash model gives each lane its own count of busy polls. It also has a mode in which lane 0 shows true data on exactly one poll and complemented data after that. The response must then arrive with lane 0 complemented. A lane that never completes drives the poll counter to its limit, and that case is counted read by read.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_PROG = 2'd1, OP_SERASE = 2'd2, OP_CERASE = 2'd3} op_e;
  typedef enum logic [2:0] {ST_IDLE, ST_WLO, ST_WHI, ST_GAP, ST_RD, ST_RSP} st_e;

  localparam logic [14:0] UNLK_A = 15'h5555;
  localparam logic [14:0] UNLK_B = 15'h2AAA;

  function automatic logic [2:0] prefix_len(op_e op);
    case (op)
      OP_PROG:   return 3'd3;
      OP_SERASE: return 3'd5;
      OP_CERASE: return 3'd6;
      default:   return 3'd0;
    endcase
  endfunction

  function automatic logic [14:0] prefix_addr(logic [2:0] idx);
    return (idx == 3'd1 || idx == 3'd4) ? UNLK_B : UNLK_A;
  endfunction

  function automatic logic [7:0] prefix_byte(op_e op, logic [2:0] idx);
    case (idx)
      3'd0, 3'd3: return 8'hAA;
      3'd1, 3'd4: return 8'h55;
      3'd2:       return (op == OP_PROG) ? 8'hA0 : 8'h80;
      3'd5:       return 8'h10;
      default:    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
  parameter int TW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nor_seq_poll.sv
module nor_seq_poll #(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sample_i,
  input  logic [LANES-1:0] dq7_i,
  input  logic [LANES-1:0] exp7_i,
  output logic             all_next_o
);
  logic [LANES-1:0] done_q;
  logic [LANES-1:0] hit;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign hit[l] = (dq7_i[l] == exp7_i[l]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 done_q[l] <= 1'b0;
      else if (clr_i)              done_q[l] <= 1'b0;
      else if (sample_i && hit[l]) done_q[l] <= 1'b1;
    end
  end

  // a lane counts as complete if it completed earlier or completes on this sample
  assign all_next_o = &(done_q | hit);

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (done_q == '0)); // R7
endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_seq_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int AW       = 17,
  parameter int NSEC     = 8,
  parameter int CLK_NS   = 10,
  parameter int T_WP_NS  = 35,
  parameter int T_AH_NS  = 45,
  parameter int T_DS_NS  = 30,
  parameter int T_WPH_NS = 20,
  parameter int T_ACC_NS = 70,
  parameter int T_OEH_NS = 10,
  parameter int POLL_MAX = 4096
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [1:0]           req_op_i,
  input  logic [AW-1:0]        req_addr_i,
  input  logic [8*LANES-1:0]   req_data_i,
  input  logic [NSEC-1:0]      req_sect_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_err_o,
  output logic [8*LANES-1:0]   rsp_data_o,
  output logic [AW-1:0]        fl_addr_o,
  output logic [8*LANES-1:0]   fl_dq_o,
  output logic                 fl_dq_oe_o,
  input  logic [8*LANES-1:0]   fl_dq_i,
  output logic [LANES-1:0]     fl_cs_no,
  output logic [LANES-1:0]     fl_we_no,
  output logic                 fl_oe_no
);
  localparam int DW     = 8 * LANES;
  localparam int SEC_W  = $clog2(NSEC);
  localparam int LOW_NS = (T_WP_NS > T_AH_NS) ? ((T_WP_NS > T_DS_NS) ? T_WP_NS : T_DS_NS)
                                              : ((T_AH_NS > T_DS_NS) ? T_AH_NS : T_DS_NS);
  localparam int LOW_C0  = (LOW_NS + CLK_NS - 1) / CLK_NS;
  localparam int HIGH_C0 = (T_WPH_NS + CLK_NS - 1) / CLK_NS;
  localparam int RD_C0   = (T_ACC_NS + CLK_NS - 1) / CLK_NS;
  localparam int OEH_C0  = (T_OEH_NS + CLK_NS - 1) / CLK_NS;
  localparam int LOW_CYC  = (LOW_C0  < 1) ? 1 : LOW_C0;
  localparam int HIGH_CYC = (HIGH_C0 < 1) ? 1 : HIGH_C0;
  localparam int RD_CYC   = (RD_C0   < 1) ? 1 : RD_C0;
  localparam int OEH_CYC  = (OEH_C0  < 1) ? 1 : OEH_C0;
  localparam int MAX_AB  = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAX_CD  = (RD_CYC > OEH_CYC) ? RD_CYC : OEH_CYC;
  localparam int MAXC    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TW      = $clog2(MAXC + 1);
  localparam int PW      = $clog2(POLL_MAX + 1);

  st_e              st_q, st_d;
  op_e              op_q;
  logic [AW-1:0]    addr_q, poll_addr_q;
  logic [DW-1:0]    data_q, rsp_data_q;
  logic [NSEC-1:0]  sect_q;
  logic [2:0]       idx_q;
  logic [PW-1:0]    poll_cnt_q;
  logic             rsp_err_q;
  logic [LANES-1:0] exp7_q, req_b7, dq7;
  logic [SEC_W-1:0] low_sec, req_low_sec;
  logic [AW-1:0]    wr_addr;
  logic [DW-1:0]    wr_data;
  logic             in_prefix, wr_last, accept, tmr_load, tmr_zero, all_next, poll_sample;
  logic [TW-1:0]    tmr_val;
  op_e              req_op;

  assign req_op = op_e'(req_op_i);
  assign accept = (st_q == ST_IDLE) && req_valid_i;

  for (genvar l = 0; l < LANES; l++) begin : g_b7
    assign req_b7[l] = req_data_i[8*l+7];
    assign dq7[l]    = fl_dq_i[8*l+7];
  end

  always_comb begin
    low_sec     = '0;
    req_low_sec = '0;
    for (int i = NSEC - 1; i >= 0; i--) begin
      if (sect_q[i])     low_sec     = SEC_W'(i);
      if (req_sect_i[i]) req_low_sec = SEC_W'(i);
    end
  end

  // current bus write: unlock/command prefix, then program word or sector targets
  assign in_prefix = (idx_q < prefix_len(op_q));
  always_comb begin
    if (in_prefix) begin
      wr_addr = AW'(prefix_addr(idx_q));
      wr_data = {LANES{prefix_byte(op_q, idx_q)}};
    end else if (op_q == OP_PROG) begin
      wr_addr = addr_q;
      wr_data = data_q;
    end else begin
      wr_addr = {low_sec, {(AW-SEC_W){1'b0}}};
      wr_data = {LANES{8'h30}};
    end
  end
  assign wr_last = in_prefix ? (op_q == OP_CERASE && idx_q == 3'd5)
                             : (op_q == OP_PROG ||
                                (sect_q & (sect_q - {{(NSEC-1){1'b0}}, 1'b1})) == '0);

  nor_seq_timer #(.TW(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  assign poll_sample = (st_q == ST_RD) && tmr_zero && (op_q != OP_READ);

  nor_seq_poll #(.LANES(LANES)) u_poll (
    .clk_i, .rst_ni, .clr_i(accept), .sample_i(poll_sample),
    .dq7_i(dq7), .exp7_i(exp7_q), .all_next_o(all_next)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        tmr_load = 1'b1;
        if (req_op == OP_READ) begin
          st_d = ST_RD;  tmr_val = TW'(RD_CYC - 1);
        end else if (req_op == OP_SERASE && req_sect_i == '0) begin
          st_d = ST_RSP;
        end else begin
          st_d = ST_WLO; tmr_val = TW'(LOW_CYC - 1);
        end
      end
      ST_WLO: if (tmr_zero) begin
        st_d = ST_WHI; tmr_load = 1'b1; tmr_val = TW'(HIGH_CYC - 1);
      end
      ST_WHI: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (wr_last) begin st_d = ST_GAP; tmr_val = TW'(OEH_CYC - 1); end
        else         begin st_d = ST_WLO; tmr_val = TW'(LOW_CYC - 1); end
      end
      ST_GAP: if (tmr_zero) begin
        st_d = ST_RD; tmr_load = 1'b1; tmr_val = TW'(RD_CYC - 1);
      end
      ST_RD: if (tmr_zero) begin
        if (op_q == OP_READ || all_next || poll_cnt_q == PW'(POLL_MAX - 1)) begin
          st_d = ST_RSP;
        end else begin
          st_d = ST_GAP; tmr_load = 1'b1; tmr_val = TW'(OEH_CYC - 1);
        end
      end
      ST_RSP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      op_q        <= OP_READ;
      addr_q      <= '0;
      poll_addr_q <= '0;
      data_q      <= '0;
      sect_q      <= '0;
      idx_q       <= '0;
      poll_cnt_q  <= '0;
      rsp_err_q   <= 1'b0;
      rsp_data_q  <= '0;
      exp7_q      <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        op_q       <= req_op;
        addr_q     <= req_addr_i;
        data_q     <= req_data_i;
        sect_q     <= req_sect_i;
        idx_q      <= '0;
        poll_cnt_q <= '0;
        rsp_err_q  <= (req_op == OP_SERASE) && (req_sect_i == '0);
        exp7_q     <= (req_op == OP_PROG) ? req_b7 : '1;
        case (req_op)
          OP_SERASE: poll_addr_q <= {req_low_sec, {(AW-SEC_W){1'b0}}};
          OP_CERASE: poll_addr_q <= '0;
          default:   poll_addr_q <= req_addr_i;
        endcase
      end
      if (st_q == ST_WHI && tmr_zero && !wr_last) begin
        if (in_prefix)              idx_q  <= idx_q + 3'd1;
        else if (op_q == OP_SERASE) sect_q <= sect_q & (sect_q - {{(NSEC-1){1'b0}}, 1'b1});
      end
      if (st_q == ST_RD && tmr_zero) begin
        rsp_data_q <= fl_dq_i;
        if (op_q != OP_READ) begin
          poll_cnt_q <= poll_cnt_q + 1'b1;
          if (!all_next && poll_cnt_q == PW'(POLL_MAX - 1)) rsp_err_q <= 1'b1;
        end
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = (st_q == ST_RSP);
  assign rsp_err_o   = rsp_err_q;
  assign rsp_data_o  = rsp_data_q;
  assign fl_dq_oe_o  = (st_q == ST_WLO) || (st_q == ST_WHI);
  assign fl_addr_o   = fl_dq_oe_o ? wr_addr :
                       (st_q == ST_RD || st_q == ST_GAP) ? poll_addr_q : '0;
  assign fl_dq_o     = fl_dq_oe_o ? wr_data : '0;
  assign fl_cs_no    = {LANES{!(fl_dq_oe_o || st_q == ST_RD)}};
  assign fl_we_no    = {LANES{st_q != ST_WLO}};
  assign fl_oe_no    = (st_q != ST_RD);

  // low-run counter for checking the strobe width
  logic [TW:0] we_low_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           we_low_run_q <= '0;
    else if (!fl_we_no[0]) we_low_run_q <= we_low_run_q + 1'b1;
    else                   we_low_run_q <= '0;
  end

  AST_WE_WIDTH:    assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_we_no[0]) |-> (we_low_run_q == (TW+1)'(LOW_CYC))); // R4
  AST_LANES_LOCK:  assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fl_we_no == '0) || (fl_we_no == '1)) && ((fl_cs_no == '0) || (fl_cs_no == '1))); // R4
  AST_NO_OE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> (!fl_dq_oe_o && fl_we_no == '1)); // R4
  AST_RSP_PULSE:   assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R10
  AST_BUSY_AFTER:  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R10
  AST_POLL_BOUND:  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD) |-> (poll_cnt_q < PW'(POLL_MAX))); // R8
endmodule

// File: tb/tb_nor_seq.sv
module tb_nor_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LOW_C  = 5;
  localparam int HIGH_C = 2;
  localparam int RD_C   = 7;
  localparam int OEH_C  = 1;
  localparam int PMAX   = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [16:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [7:0]  req_sect = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_data;
  logic [16:0] fl_addr;
  logic [31:0] fl_dq_o, fl_dq_i;
  logic        fl_dq_oe, fl_oe_n;
  logic [3:0]  fl_cs_n, fl_we_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_seq #(.CLK_NS(CLK_PERIOD), .POLL_MAX(PMAX)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_data_i(req_data), .req_sect_i(req_sect),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_data_o(rsp_data),
    .fl_addr_o(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe_o(fl_dq_oe), .fl_dq_i(fl_dq_i),
    .fl_cs_no(fl_cs_n), .fl_we_no(fl_we_n), .fl_oe_no(fl_oe_n)
  );

  int nchk = 0, nbad = 0;

  // flash model
  bit          mode_rd = 1'b1;
  bit          flaky0 = 1'b0;
  logic [31:0] rd_word = '0, exp_word = '0;
  int          lane_dly [4];
  int          rd_cnt = 0;

  always_comb begin
    for (int l = 0; l < 4; l++) begin
      if (mode_rd) fl_dq_i[8*l +: 8] = rd_word[8*l +: 8];
      else if (rd_cnt > lane_dly[l] && !(flaky0 && l == 0 && rd_cnt > lane_dly[0] + 1))
        fl_dq_i[8*l +: 8] = exp_word[8*l +: 8];
      else
        fl_dq_i[8*l +: 8] = ~exp_word[8*l +: 8];
    end
  end

  // bus monitor
  logic [16:0] wr_a [16];
  logic [31:0] wr_d [16];
  int   wr_n = 0, viol = 0, low_len = 0, high_len = 1000, since_we = 1000, oe_len = 0, last_oe_len = 0;
  logic [16:0] rd_addr = '0;
  logic prev_we = 1'b1, prev_oe = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!(fl_we_n == 4'h0 || fl_we_n == 4'hF) || !(fl_cs_n == 4'h0 || fl_cs_n == 4'hF)) viol++;
      if (!fl_we_n[0] && (fl_cs_n != 4'h0 || !fl_oe_n)) viol++;
      if (!fl_we_n[0]) begin
        if (prev_we) begin
          if (wr_n < 16) begin wr_a[wr_n] = fl_addr; wr_d[wr_n] = fl_dq_o; end
          wr_n++;
          if (high_len < HIGH_C) viol++;
        end
        low_len++;
      end else begin
        if (!prev_we) begin
          if (low_len != LOW_C) viol++;
          low_len = 0; high_len = 0; since_we = 0;
        end
        high_len++; since_we++;
      end
      if (!fl_oe_n) begin
        if (prev_oe) begin
          rd_cnt++; rd_addr = fl_addr;
          if (since_we <= OEH_C) viol++;
        end
        oe_len++;
      end else if (!prev_oe) begin
        last_oe_len = oe_len; oe_len = 0;
      end
      prev_we = fl_we_n[0];
      prev_oe = fl_oe_n;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic clr_model();
    wr_n = 0; viol = 0; rd_cnt = 0; high_len = 1000; since_we = 1000;
    flaky0 = 1'b0;
    for (int l = 0; l < 4; l++) lane_dly[l] = 0;
  endtask

  logic        got_err;
  logic [31:0] got_data;

  task automatic run_req(input logic [1:0] op, input logic [16:0] a, input logic [31:0] d,
                         input logic [7:0] s);
    int n;
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; req_sect = s; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "ready low while busy", {31'd0, req_ready}, 32'd0);
    n = 0;
    while (!rsp_valid && n < 5000) begin @(negedge clk); n++; end
    chk("R10", "response arrived", {31'd0, rsp_valid}, 32'd1);
    got_err = rsp_err; got_data = rsp_data;
    @(negedge clk);
    chk("R10", "single pulse then ready", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic chk_wr(input string req, input int i, input logic [16:0] a, input logic [31:0] d);
    chk(req, $sformatf("write %0d addr", i), {15'd0, wr_a[i]}, {15'd0, a});
    chk(req, $sformatf("write %0d data", i), wr_d[i], d);
  endtask

  task automatic t_reset();
    chk("R1", "idle outputs", {26'd0, req_ready, rsp_valid, fl_dq_oe, fl_oe_n, fl_cs_n == 4'hF, fl_we_n == 4'hF},
        32'b100111);
  endtask

  task automatic t_read();
    clr_model(); mode_rd = 1'b1; rd_word = 32'hDEAD_BEEF;
    run_req(2'd0, 17'h01234, 32'h0, 8'h0);
    chk("R2", "read data", got_data, 32'hDEAD_BEEF);
    chk("R2", "read err", {31'd0, got_err}, 32'd0);
    chk("R2", "no writes, one read", {wr_n[15:0], rd_cnt[15:0]}, {16'd0, 16'd1});
    chk("R2", "read addr", {15'd0, rd_addr}, 32'h1234);
    chk("R2", "oe low width", last_oe_len, RD_C);
  endtask

  task automatic t_program();
    clr_model(); mode_rd = 1'b0; exp_word = 32'h8015_7F80;
    lane_dly[0] = 0; lane_dly[1] = 2; lane_dly[2] = 1; lane_dly[3] = 3;
    run_req(2'd1, 17'h0ABCD, exp_word, 8'h0);
    chk("R3", "write count", wr_n, 4);
    chk_wr("R3", 0, 17'h05555, 32'hAAAA_AAAA);
    chk_wr("R3", 1, 17'h02AAA, 32'h5555_5555);
    chk_wr("R3", 2, 17'h05555, 32'hA0A0_A0A0);
    chk_wr("R3", 3, 17'h0ABCD, 32'h8015_7F80);
    chk("R4", "strobe timing violations", viol, 0);
    chk("R7", "poll count to slowest lane", rd_cnt, 4);
    chk("R7", "poll addr", {15'd0, rd_addr}, 32'h0ABCD);
    chk("R7", "result", {got_err, got_data[30:0]}, {1'b0, exp_word[30:0]});
  endtask

  task automatic t_sticky();
    clr_model(); mode_rd = 1'b0; exp_word = 32'h0102_0380;
    flaky0 = 1'b1; lane_dly[1] = 2; lane_dly[2] = 2; lane_dly[3] = 2;
    run_req(2'd1, 17'h00040, exp_word, 8'h0);
    chk("R7", "sticky lane poll count", rd_cnt, 3);
    chk("R7", "sticky lane data", got_data, {exp_word[31:8], ~exp_word[7:0]});
    chk("R7", "sticky lane err", {31'd0, got_err}, 32'd0);
  endtask

  task automatic t_sector();
    clr_model(); mode_rd = 1'b0; exp_word = 32'hFFFF_FFFF;
    for (int l = 0; l < 4; l++) lane_dly[l] = 1;
    run_req(2'd2, 17'h0, 32'h0, 8'b1010_0100);
    chk("R5", "write count", wr_n, 8);
    chk_wr("R5", 0, 17'h05555, 32'hAAAA_AAAA);
    chk_wr("R5", 1, 17'h02AAA, 32'h5555_5555);
    chk_wr("R5", 2, 17'h05555, 32'h8080_8080);
    chk_wr("R5", 3, 17'h05555, 32'hAAAA_AAAA);
    chk_wr("R5", 4, 17'h02AAA, 32'h5555_5555);
    chk_wr("R5", 5, 17'h08000, 32'h3030_3030);
    chk_wr("R5", 6, 17'h14000, 32'h3030_3030);
    chk_wr("R5", 7, 17'h1C000, 32'h3030_3030);
    chk("R4", "strobe timing violations", viol, 0);
    chk("R7", "erase poll addr and count", {15'd0, rd_addr} | (rd_cnt << 20), 32'h0020_8000);
    chk("R7", "erase ok", {31'd0, got_err}, 32'd0);
  endtask

  task automatic t_chip();
    clr_model(); mode_rd = 1'b0; exp_word = 32'hFFFF_FFFF;
    lane_dly[3] = 2;
    run_req(2'd3, 17'h1FFFF, 32'h0, 8'hFF);
    chk("R6", "write count", wr_n, 6);
    chk_wr("R6", 2, 17'h05555, 32'h8080_8080);
    chk_wr("R6", 5, 17'h05555, 32'h1010_1010);
    chk("R7", "chip poll addr", {15'd0, rd_addr}, 32'h0);
    chk("R7", "chip poll count", rd_cnt, 3);
    chk("R4", "strobe timing violations", viol, 0);
  endtask

  task automatic t_empty();
    clr_model(); mode_rd = 1'b0;
    run_req(2'd2, 17'h0, 32'h0, 8'h00);
    chk("R9", "empty mask err", {31'd0, got_err}, 32'd1);
    chk("R9", "no bus cycles", wr_n + rd_cnt, 0);
  endtask

  task automatic t_timeout();
    clr_model(); mode_rd = 1'b0; exp_word = 32'h1122_3344;
    lane_dly[2] = 100;
    run_req(2'd1, 17'h00010, exp_word, 8'h0);
    chk("R8", "timeout err", {31'd0, got_err}, 32'd1);
    chk("R8", "poll reads at limit", rd_cnt, PMAX);
  endtask

  initial begin : wdog
    int cyc;
    cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    nchk++; nbad++;
    $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    for (int l = 0; l < 4; l++) lane_dly[l] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read();
    t_program();
    t_sticky();
    t_sector();
    t_chip();
    t_empty();
    t_timeout();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule